// File: doc/BRIEF.md
# Serial Register File Slave

This block is a serial slave that lets a host load a small bank of configuration registers over four wires. The pins are an active-low select, a serial clock and a serial data input, plus a serial data output that can be switched off. The host sends 16-bit frames with the least significant bit first. The first three bits name one of eight registers and the other thirteen bits are the new contents. A frame only writes its register if the select rises after exactly sixteen clock pulses. Frames that are shorter or longer than that leave every register unchanged.

The same frame also reads. When select falls, the output immediately shows a fault flag, which is the OR of the core's status inputs. Two more header bits follow: one says the previous frame was rejected for its length, the other says the previous frame was a complete frame aimed at the read-only register. After those three header bits, the thirteen bits of the addressed register appear, least significant first, using the value the register held before this frame's write. The eighth register is not writable. Reading it returns the core's status word.

The block runs on a system clock. The three serial pins pass through a small synchronizer, and serial clock edges are detected in the system clock domain. The output data never repeats the input data. Because of this, slaves cannot be chained, and each slave needs its own select line.

Top module: `spi_regfile_slave`

## Requirements
- R1: After a synchronous reset, every writable register reads as zero on `cfg_o` and `miso_oe` is low.
- R2: `miso_oe` is low while `sel_n` is high, and it is high for the whole time `sel_n` is low during a frame.
- R3: The first output bit, present after `sel_n` falls and before the first rising edge of `sclk`, equals the OR of all bits of `status_i`.
- R4: `mosi` is sampled on rising `sclk` edges. Frame bit 0 is address bit 0, bits 0 to 2 form the address, and bits 3 to 15 are data bits 0 to 12. A frame of exactly 16 bits to an address from 0 to 6 loads those data bits into that register (`cfg_o[addr*13 +: 13]`) when `sel_n` rises.
- R5: A frame with fewer than 16 rising `sclk` edges, including zero, changes no register.
- R6: A frame with more than 16 rising `sclk` edges changes no register.
- R7: Output bits 3 to 15 of a frame, which change on falling `sclk` edges, are bits 0 to 12 of the addressed register as it stood before the frame.
- R8: Output bit 1 is 1 when the previous frame had a length other than 16. Output bit 2 is 1 when the previous frame was a complete 16-bit frame to address 7. Both bits are 0 after reset.
- R9: Address 7 is read-only. Its readback is `status_i`, and a complete frame to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for the `miso` driver (high impedance when low) |
| status_i | input | 13 | Status flags from the core, readable at address 7 |
| cfg_o | output | 91 | Seven writable 13-bit registers, register n at bits n*13 and up |

## Verification
The embedded properties are checked on every cycle. They cover these facts: the output enable drops whenever select is idle, and the bit counter never passes its saturation value. The first output bit after select falls carries the fault flag. A write never targets the read-only address, and the register outputs hold still in any cycle without a write. Other behaviour needs whole frames and so only the bench scenarios can show it: frames of each length are accepted or rejected, the readback bits arrive in order within one frame, and the header reports the fate of the previous frame. The bench sweeps every address with computed patterns and a range of short and long frame lengths, so these cases are covered.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 13;
    localparam int NREG      = 1 << ADDR_W;
    localparam int FRAME_LEN = ADDR_W + DATA_W;

    typedef struct packed {
        logic prev_rej;
        logic prev_ro;
    } hdr_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
        logic [W-1:0]             last;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = pin_i;
        for (int i = 1; i < STAGES; i++) st_d.stg[i] = st_q.stg[i-1];
        st_d.last = st_q.stg[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st_q.stg[i] <= INIT;
            st_q.last <= INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o  = st_q.stg[STAGES-1];
    assign rise_o = st_q.stg[STAGES-1] & ~st_q.last;
    assign fall_o = ~st_q.stg[STAGES-1] & st_q.last;
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
    import spi_rf_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_act,
    input  logic          sel_rise,
    input  logic          sclk_rise,
    input  logic          mosi_s,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          hdr_load,
    output logic          rd_load,
    output logic [AW-1:0] rd_addr,
    output hdr_t          hdr
);
    localparam int FLEN  = AW + DW;
    localparam int SAT   = FLEN + 1;
    localparam int CW    = $clog2(SAT + 1);
    localparam logic [AW-1:0] RO_ADDR = {AW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        hdr_t          hdr;
    } st_t;

    st_t st_d, st_q;
    logic full_len;

    assign full_len = (st_q.cnt == CW'(FLEN));

    always_comb begin
        st_d = st_q;
        if (sel_rise) begin
            st_d.hdr.prev_rej = !full_len;
            st_d.hdr.prev_ro  = full_len && (st_q.addr == RO_ADDR);
        end
        if (!sel_act) begin
            st_d.cnt = '0;
        end else if (sclk_rise) begin
            for (int i = 0; i < AW; i++)
                if (st_q.cnt == CW'(i)) st_d.addr[i] = mosi_s;
            for (int i = 0; i < DW; i++)
                if (st_q.cnt == CW'(i + AW)) st_d.data[i] = mosi_s;
            if (st_q.cnt != CW'(SAT)) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en    = sel_rise && full_len && (st_q.addr != RO_ADDR);
    assign wr_addr  = st_q.addr;
    assign wr_data  = st_q.data;
    assign hdr_load = sel_act && sclk_rise && (st_q.cnt == '0);
    assign rd_load  = sel_act && sclk_rise && (st_q.cnt == CW'(AW - 1));
    assign rd_addr  = {mosi_s, st_q.addr[AW-2:0]};
    assign hdr      = st_q.hdr;

    // R6
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CW'(SAT));

    // R2
    idle_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_act |=> st_q.cnt == '0 || sel_act);
endmodule

// File: rtl/spi_tx.sv
module spi_tx
    import spi_rf_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int FLEN = FRAME_LEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_act,
    input  logic          sel_fall,
    input  logic          sclk_fall,
    input  logic          fault,
    input  logic          hdr_load,
    input  hdr_t          hdr,
    input  logic          rd_load,
    input  logic [DW-1:0] rd_data,
    output logic          miso,
    output logic          miso_oe
);
    localparam int SW = FLEN - 1;

    typedef struct packed {
        logic          oe;
        logic          bit_out;
        logic [SW-1:0] sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!sel_act) begin
            st_d.oe      = 1'b0;
            st_d.bit_out = 1'b0;
        end else begin
            st_d.oe = 1'b1;
            if (sel_fall) st_d.bit_out = fault;
            if (hdr_load)
                st_d.sh = {{(SW-2){1'b0}}, hdr.prev_ro, hdr.prev_rej};
            else if (rd_load)
                st_d.sh = {{(SW-DW){1'b0}}, rd_data};
            else if (sclk_fall) begin
                st_d.bit_out = st_q.sh[0];
                st_d.sh      = st_q.sh >> 1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign miso    = st_q.bit_out;
    assign miso_oe = st_q.oe;

    // R2
    oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_act |=> !miso_oe);
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
    import spi_rf_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [DW-1:0]                 wr_data,
    input  logic [AW-1:0]                 rd_addr,
    output logic [DW-1:0]                 rd_data,
    input  logic [DW-1:0]                 status_i,
    output logic [((1<<AW)-1)*DW-1:0]     cfg_o
);
    localparam int NW = (1 << AW) - 1;
    localparam logic [AW-1:0] RO_ADDR = {AW{1'b1}};

    typedef struct packed {
        logic [NW-1:0][DW-1:0] r;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NW; i++)
            if (wr_en && wr_addr == AW'(i)) st_d.r[i] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = status_i;
        for (int i = 0; i < NW; i++)
            if (rd_addr == AW'(i)) rd_data = st_q.r[i];
    end

    for (genvar g = 0; g < NW; g++) begin : g_out
        assign cfg_o[g*DW +: DW] = st_q.r[g];
    end

    // R9
    ro_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_addr != RO_ADDR);
endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
    import spi_rf_pkg::*;
#(
    parameter int AW          = ADDR_W,
    parameter int DW          = DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sel_n,
    input  logic                      sclk,
    input  logic                      mosi,
    output logic                      miso,
    output logic                      miso_oe,
    input  logic [DW-1:0]             status_i,
    output logic [((1<<AW)-1)*DW-1:0] cfg_o
);
    localparam int FLEN = AW + DW;

    logic [2:0] lvl, rise, fall;
    logic       sel_act, fault;
    logic       wr_en, hdr_load, rd_load;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [DW-1:0] wr_data, rd_data;
    hdr_t       hdr;

    spi_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
        .clk(clk), .rst(rst), .pin_i({sel_n, sclk, mosi}),
        .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    assign sel_act = !lvl[2];
    assign fault   = |status_i;

    spi_frame_rx #(.AW(AW), .DW(DW)) u_rx (
        .clk(clk), .rst(rst), .sel_act(sel_act), .sel_rise(rise[2]),
        .sclk_rise(rise[1]), .mosi_s(lvl[0]),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hdr_load(hdr_load), .rd_load(rd_load), .rd_addr(rd_addr), .hdr(hdr)
    );

    spi_regbank #(.AW(AW), .DW(DW)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .status_i(status_i), .cfg_o(cfg_o)
    );

    spi_tx #(.DW(DW), .FLEN(FLEN)) u_tx (
        .clk(clk), .rst(rst), .sel_act(sel_act), .sel_fall(fall[2]),
        .sclk_fall(fall[1]), .fault(fault), .hdr_load(hdr_load), .hdr(hdr),
        .rd_load(rd_load), .rd_data(rd_data), .miso(miso), .miso_oe(miso_oe)
    );

    // R3
    fault_lead_chk: assert property (@(posedge clk) disable iff (rst)
        fall[2] |=> miso_oe && (miso == $past(fault)));

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_o));
endmodule

// File: tb/sim_spi_regfile_slave.sv
module sim_spi_regfile_slave;
    localparam int DW = 13;
    localparam int NW = 7;

    logic clk = 0, rst = 1;
    logic sel_n = 1, sclk = 0, mosi = 0;
    logic miso, miso_oe;
    logic [DW-1:0] status_i = '0;
    logic [NW*DW-1:0] cfg_o;

    int errors = 0, checks = 0;
    bit done = 0;

    logic [DW-1:0] model [NW];
    logic m_rej = 0, m_ro = 0;
    logic oe_bad;

    always #5 clk = ~clk;

    spi_regfile_slave u0 (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .status_i(status_i), .cfg_o(cfg_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input int nbits, input logic [2:0] a,
                        input logic [DW-1:0] d, output logic [15:0] rx);
        logic [15:0] fr;
        fr = {d, a};
        rx = '0;
        oe_bad = 0;
        sel_n = 0;
        idle(6);
        rx[0] = miso;
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? fr[i] : 1'b0;
            idle(6);
            if (i < 16) rx[i] = miso;
            if (!miso_oe) oe_bad = 1;
            sclk = 1;
            idle(6);
            sclk = 0;
        end
        idle(6);
        if (!miso_oe) oe_bad = 1;
        sel_n = 1;
        idle(8);
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int k);
        return DW'((a * 13'h0333) ^ (k * 13'h1A5) ^ 13'h0F0F);
    endfunction

    task automatic chk_cfg(input string req);
        for (int a = 0; a < NW; a++)
            chk(cfg_o[a*DW +: DW] == model[a], req, cfg_o[a*DW +: DW], model[a]);
    endtask

    // full frame with header and readback checks, model update
    task automatic frame(input int nbits, input logic [2:0] a, input logic [DW-1:0] d);
        logic [15:0] rx;
        logic [DW-1:0] old;
        old = (a == 3'd7) ? status_i : model[a];
        xfer(nbits, a, d, rx);
        chk(!oe_bad, "R2 oe during frame", {31'b0, oe_bad}, 0);
        chk(rx[0] == |status_i, "R3 fault lead bit", rx[0], |status_i);
        if (nbits >= 3) begin
            chk(rx[1] == m_rej, "R8 prev reject bit", rx[1], m_rej);
            chk(rx[2] == m_ro, "R8 prev read-only bit", rx[2], m_ro);
        end
        if (nbits >= 16)
            chk(rx[15:3] == old, (a == 3'd7) ? "R9 status readback" : "R7 readback",
                rx[15:3], old);
        m_rej = (nbits != 16);
        m_ro  = (nbits == 16) && (a == 3'd7);
        if (nbits == 16 && a != 3'd7) model[a] = d;
        chk(miso_oe == 0, "R2 oe idle", miso_oe, 0);
    endtask

    initial begin
        for (int a = 0; a < NW; a++) model[a] = '0;
        idle(4);
        rst = 0;
        idle(4);
        // R1 reset state
        chk(miso_oe == 0, "R1 oe after reset", miso_oe, 0);
        chk_cfg("R1 cfg after reset");
        // R4 write sweep, then R7 readback with new pattern
        for (int k = 0; k < 3; k++)
            for (int a = 0; a < NW; a++) begin
                frame(16, 3'(a), pat(a, k));
                chk_cfg("R4 exact frame write");
            end
        // R5 short frames
        for (int n = 0; n < 16; n += 3) begin
            frame(n, 3'd2, 13'h1FFF ^ DW'(n));
            chk_cfg("R5 short frame ignored");
        end
        frame(15, 3'd4, 13'h0AAA);
        chk_cfg("R5 fifteen-bit frame ignored");
        frame(16, 3'd0, 13'h1234);
        // R6 long frames
        for (int n = 17; n < 24; n += 3) begin
            frame(n, 3'd5, 13'h0555 ^ DW'(n));
            chk_cfg("R6 long frame ignored");
        end
        frame(16, 3'd5, 13'h0C3C);
        chk_cfg("R4 write after rejects");
        // R9 read-only address with status, R3 fault set
        status_i = 13'h00A5;
        frame(16, 3'd7, 13'h1FFF);
        chk_cfg("R9 read-only write ignored");
        frame(16, 3'd7, 13'h0000);
        status_i = 13'h1000;
        frame(16, 3'd3, 13'h0777);
        status_i = '0;
        for (int a = 0; a < NW; a++) frame(16, 3'(a), pat(a, 9));
        chk_cfg("R4 final sweep");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule